// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block turns a serial receive line back into parallel characters. The line rests high. A falling edge starts a character. In the oversampled rates the receiver checks again half a bit later that the line is still low, and a line that has gone high again counts as noise. After a valid start it samples every data bit, the optional parity bit and the stop bit at the centre of its bit period. The finished character goes to a one-deep output holding register and a ready flag is raised.

Parity errors, framing errors and overruns are gathered in sticky flags. An error never stops reception. The flags clear only on an explicit clear pulse. A read pulse from the host drops the ready flag. The character shape is set by a mode word: length from five to eight bits, parity on or off, even or odd parity, and a clock factor of 1, 16 or 64 receive clocks per bit. The mode is taken once per character, on the start edge.

Top module: `async_char_rx`

## Requirements
- R1: After reset `rx_data` is 0 and `rx_ready`, `err_parity`, `err_frame` and `err_overrun` are all low. They stay that way while the line is held high.
- R2: In the 16x and 64x rates, a high-to-low change of `rxd` starts a character. The line is sampled again half a bit period (factor/2 clocks) after the edge. If it is high there, the character is dropped with no flag or data change, and the receiver waits for the next falling edge.
- R3: The data bits come least significant bit first. Each is sampled one full bit period (factor clocks) after the sample before it. `mode_rate` code 1 selects 16x, and codes 2 and 3 both select 64x.
- R4: `mode_rate` code 0 selects 1x. The clock that sees the falling edge counts as the start bit, with no second check, and each following bit is sampled on the next consecutive clock.
- R5: `mode_len` codes 0, 1, 2 and 3 give 5, 6, 7 and 8 data bits. Bits of `rx_data` above the character length read 0.
- R6: When `mode_par_en` is 1, a parity bit follows the data. With `mode_par_even` at 1 the count of ones over data and parity must be even, and with 0 it must be odd. A mismatch sets `err_parity`.
- R7: A low stop-bit sample sets `err_frame`. The character is still delivered.
- R8: The clock edge that samples the stop bit loads `rx_data` and sets `rx_ready`. A `rd_strobe` clears `rx_ready`. A load in the same cycle as a read wins.
- R9: A character that completes while `rx_ready` is still set and no read is present replaces the old data and sets `err_overrun`.
- R10: The error flags stay set until `err_clear`. An error raised in the same cycle as a clear wins. Reception goes on normally after any error.
- R11: The mode inputs are captured at the start edge. A change during a character takes effect from the next character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock; all samples are taken on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial receive line, idle high |
| mode_len | input | 2 | Character length code (5 + code bits) |
| mode_par_en | input | 1 | Parity bit present when 1 |
| mode_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| mode_rate | input | 2 | Clock factor: 0 = 1x, 1 = 16x, 2 or 3 = 64x |
| rd_strobe | input | 1 | Host read pulse; clears the ready flag |
| err_clear | input | 1 | Clears all three error flags |
| rx_data | output | 8 | Last received character, zero-filled above its length |
| rx_ready | output | 1 | A character is waiting to be read |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun error |

## Verification
The receiver is driven with well-formed characters at all three clock factors and all four lengths. All-ones and mixed patterns show whether the bit order is right and whether the upper bits are cleared. The same characters are also sent with good and bad parity, in both parity senses, and with a low stop bit. This separates the parity check from the framing check, and both from normal delivery. A short low pulse is sent at 16x, where it must be dropped, and at 1x, where it must be taken as a start bit. Back-to-back characters sent without a read check the overrun rule, and a length change in the middle of a character shows whether the mode is captured at the start edge.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

   // Fixed character geometry: a 2-bit length code covers MIN_LEN .. MIN_LEN+3 bits
   localparam int LEN_CODE_W = 2;
   localparam int MIN_LEN    = 5;
   localparam int DATA_W     = MIN_LEN + (1 << LEN_CODE_W) - 1;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_START = 3'd1,
      ST_DATA  = 3'd2,
      ST_PAR   = 3'd3,
      ST_STOP  = 3'd4
   } rx_state_e;

   typedef enum logic [1:0] {
      RATE_X1   = 2'd0,
      RATE_LO   = 2'd1,
      RATE_HI   = 2'd2,
      RATE_HI_B = 2'd3
   } rate_e;

   typedef struct packed {
      logic [LEN_CODE_W-1:0] len;
      logic                  par_en;
      logic                  par_even;
      rate_e                 rate;
   } rx_mode_t;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
   parameter int STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_raw,
   output logic line_out
);

   generate
      if (STAGES == 0) begin : g_pass
         assign line_out = line_raw;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '1;
            end else begin
               chain_q <= {chain_q[STAGES-2:0], line_raw};
            end
         end
         assign line_out = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic [CNT_W-1:0] limit,
   output logic             hit
);

   logic [CNT_W-1:0] cnt_q;

   assign hit = ~clear & (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear || hit) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // With a non-zero limit, two sample points can never be adjacent (R3)
   assert_hit_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && limit != '0 && !clear) |=> !hit);

endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
   import async_rx_pkg::*;
#(
   parameter int FACTOR_LO = 16,
   parameter int FACTOR_HI = 64,
   localparam int CNT_W    = $clog2(FACTOR_HI),
   localparam int IDX_W    = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line,
   input  rx_mode_t          mode_in,
   input  logic              tmr_hit,
   output logic              tmr_clear,
   output logic [CNT_W-1:0]  tmr_limit,
   output logic              ld_strobe,
   output logic [DATA_W-1:0] ld_char,
   output logic              ld_perr,
   output logic              ld_ferr
);

   rx_state_e        state_q, state_d;
   rx_mode_t         mode_q;
   logic             line_prev_q;
   logic [IDX_W-1:0] idx_q;
   logic             par_acc_q;
   logic             fall_seen;
   logic             start_go;
   logic             data_take;
   logic             last_bit;
   logic [CNT_W-1:0] full_lim;
   logic [CNT_W-1:0] half_lim;

   assign fall_seen = line_prev_q & ~line;
   assign start_go  = (state_q == ST_IDLE) & fall_seen;
   assign data_take = (state_q == ST_DATA) & tmr_hit;
   assign last_bit  = (idx_q == (IDX_W'(MIN_LEN - 1) + IDX_W'(mode_q.len)));

   // Sample spacing for the captured rate
   always_comb begin
      unique case (mode_q.rate)
         RATE_X1: begin
            full_lim = '0;
            half_lim = '0;
         end
         RATE_LO: begin
            full_lim = CNT_W'(FACTOR_LO - 1);
            half_lim = CNT_W'(FACTOR_LO / 2 - 1);
         end
         default: begin
            full_lim = CNT_W'(FACTOR_HI - 1);
            half_lim = CNT_W'(FACTOR_HI / 2 - 1);
         end
      endcase
      tmr_limit = (state_q == ST_START) ? half_lim : full_lim;
   end

   always_comb begin
      state_d   = state_q;
      tmr_clear = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            tmr_clear = 1'b1;
            if (fall_seen) begin
               state_d = (mode_in.rate == RATE_X1) ? ST_DATA : ST_START;
            end
         end
         ST_START: begin
            if (tmr_hit) begin
               state_d = line ? ST_IDLE : ST_DATA;
            end
         end
         ST_DATA: begin
            if (tmr_hit && last_bit) begin
               state_d = mode_q.par_en ? ST_PAR : ST_STOP;
            end
         end
         ST_PAR: begin
            if (tmr_hit) begin
               state_d = ST_STOP;
            end
         end
         ST_STOP: begin
            if (tmr_hit) begin
               state_d = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         line_prev_q <= 1'b1;
         mode_q      <= '0;
         idx_q       <= '0;
         par_acc_q   <= 1'b0;
      end else begin
         state_q     <= state_d;
         line_prev_q <= line;
         if (start_go) begin
            mode_q    <= mode_in;
            idx_q     <= '0;
            par_acc_q <= 1'b0;
         end else if (data_take) begin
            idx_q     <= idx_q + 1'b1;
            par_acc_q <= par_acc_q ^ line;
         end else if ((state_q == ST_PAR) && tmr_hit) begin
            par_acc_q <= par_acc_q ^ line;
         end
      end
   end

   // One capture cell per character bit; cleared at each start edge
   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               bit_q <= 1'b0;
            end else if (start_go) begin
               bit_q <= 1'b0;
            end else if (data_take && (idx_q == IDX_W'(b))) begin
               bit_q <= line;
            end
         end
         assign ld_char[b] = bit_q;
      end
   endgenerate

   assign ld_strobe = (state_q == ST_STOP) & tmr_hit;
   assign ld_ferr   = ~line;
   assign ld_perr   = mode_q.par_en & (par_acc_q ^ ~mode_q.par_even);

   // Delivered character carries no bits above its length (R5)
   assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ld_strobe |-> ((ld_char >> (MIN_LEN + int'(mode_q.len))) == '0));

endmodule

// File: rtl/rx_out_buffer.sv
module rx_out_buffer #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic [DATA_W-1:0] ld_char,
   input  logic              ld_perr,
   input  logic              ld_ferr,
   input  logic              rd_strobe,
   input  logic              err_clear,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_ready,
   output logic              err_parity,
   output logic              err_frame,
   output logic              err_overrun
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data     <= '0;
         rx_ready    <= 1'b0;
         err_parity  <= 1'b0;
         err_frame   <= 1'b0;
         err_overrun <= 1'b0;
      end else begin
         if (ld) begin
            rx_data <= ld_char;
         end
         if (ld) begin
            rx_ready <= 1'b1;
         end else if (rd_strobe) begin
            rx_ready <= 1'b0;
         end
         err_parity  <= (err_parity  & ~err_clear) | (ld & ld_perr);
         err_frame   <= (err_frame   & ~err_clear) | (ld & ld_ferr);
         err_overrun <= (err_overrun & ~err_clear) | (ld & rx_ready & ~rd_strobe);
      end
   end

endmodule

// File: rtl/async_char_rx.sv
module async_char_rx
   import async_rx_pkg::*;
#(
   parameter int FACTOR_LO   = 16,
   parameter int FACTOR_HI   = 64,
   parameter int SYNC_STAGES = 0,
   localparam int CNT_W      = $clog2(FACTOR_HI)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rxd,
   input  logic [1:0]        mode_len,
   input  logic              mode_par_en,
   input  logic              mode_par_even,
   input  logic [1:0]        mode_rate,
   input  logic              rd_strobe,
   input  logic              err_clear,
   output logic [7:0]        rx_data,
   output logic              rx_ready,
   output logic              err_parity,
   output logic              err_frame,
   output logic              err_overrun
);

   // Elaboration-time parameter checks
   if (FACTOR_LO < 2 || (FACTOR_LO & (FACTOR_LO - 1)) != 0) begin : g_chk_lo
      $error("FACTOR_LO must be a power of two of at least 2");
   end
   if (FACTOR_HI <= FACTOR_LO || (FACTOR_HI & (FACTOR_HI - 1)) != 0) begin : g_chk_hi
      $error("FACTOR_HI must be a power of two above FACTOR_LO");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES == 1) begin : g_chk_sync
      $error("SYNC_STAGES must be 0 or at least 2");
   end
   if (DATA_W != 8) begin : g_chk_w
      $error("character register must be 8 bits wide");
   end

   rx_mode_t          mode_in;
   logic              line;
   logic              tmr_clear;
   logic              tmr_hit;
   logic [CNT_W-1:0]  tmr_limit;
   logic              ld_strobe;
   logic [DATA_W-1:0] ld_char;
   logic              ld_perr;
   logic              ld_ferr;

   assign mode_in = '{len: mode_len, par_en: mode_par_en,
                      par_even: mode_par_even, rate: rate_e'(mode_rate)};

   rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_raw (rxd),
      .line_out (line)
   );

   rx_bit_timer #(.CNT_W(CNT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (tmr_clear),
      .limit (tmr_limit),
      .hit   (tmr_hit)
   );

   rx_frame_ctrl #(.FACTOR_LO(FACTOR_LO), .FACTOR_HI(FACTOR_HI)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .line      (line),
      .mode_in   (mode_in),
      .tmr_hit   (tmr_hit),
      .tmr_clear (tmr_clear),
      .tmr_limit (tmr_limit),
      .ld_strobe (ld_strobe),
      .ld_char   (ld_char),
      .ld_perr   (ld_perr),
      .ld_ferr   (ld_ferr)
   );

   rx_out_buffer #(.DATA_W(DATA_W)) u_buf (
      .clk         (clk),
      .rst_n       (rst_n),
      .ld          (ld_strobe),
      .ld_char     (ld_char),
      .ld_perr     (ld_perr),
      .ld_ferr     (ld_ferr),
      .rd_strobe   (rd_strobe),
      .err_clear   (err_clear),
      .rx_data     (rx_data),
      .rx_ready    (rx_ready),
      .err_parity  (err_parity),
      .err_frame   (err_frame),
      .err_overrun (err_overrun)
   );

   // A completed character always leaves the ready flag up (R8)
   assert_load_sets_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ld_strobe |=> rx_ready);

   // A read with no new character drops ready (R8)
   assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && !ld_strobe) |=> !rx_ready);

   // Output data moves only when a character is delivered (R8)
   assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_strobe |=> $stable(rx_data));

   // Unread character overwritten raises overrun (R9)
   assert_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_strobe && rx_ready && !rd_strobe) |=> err_overrun);

   // Error flags are sticky until cleared (R10)
   assert_frame_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (err_frame && !err_clear) |=> err_frame);
   assert_parity_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (err_parity && !err_clear) |=> err_parity);

endmodule

// File: tb/async_char_rx_tb.sv
module async_char_rx_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rxd = 1'b1;
   logic [1:0] mode_len = 2'd3;
   logic       mode_par_en = 1'b0;
   logic       mode_par_even = 1'b0;
   logic [1:0] mode_rate = 2'd1;
   logic       rd_strobe = 1'b0;
   logic       err_clear = 1'b0;
   logic [7:0] rx_data;
   logic       rx_ready, err_parity, err_frame, err_overrun;

   int  n_chk = 0;
   int  n_fail = 0;
   int  cyc = 0;
   bit  done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   async_char_rx u_dut (
      .clk(clk), .rst_n(rst_n), .rxd(rxd),
      .mode_len(mode_len), .mode_par_en(mode_par_en), .mode_par_even(mode_par_even),
      .mode_rate(mode_rate), .rd_strobe(rd_strobe), .err_clear(err_clear),
      .rx_data(rx_data), .rx_ready(rx_ready), .err_parity(err_parity),
      .err_frame(err_frame), .err_overrun(err_overrun)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int         m_phase, m_wait, m_pos, m_nbits, m_factor, m_acc;
   bit         m_pen, m_even, m_prev;
   logic [7:0] m_char;
   logic [7:0] e_data;
   bit         e_ready, e_pe, e_fe, e_oe;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_phase = 0; m_wait = 0; m_pos = 0; m_prev = 1'b1; m_char = 8'h00;
         e_data = 8'h00; e_ready = 0; e_pe = 0; e_fe = 0; e_oe = 0;
      end else begin
         bit ld, npe, nfe;
         ld = 0; npe = 0; nfe = 0;
         if (m_phase == 0) begin
            if (m_prev && !rxd) begin
               m_nbits  = 5 + int'(mode_len);
               m_pen    = mode_par_en;
               m_even   = mode_par_even;
               m_factor = (mode_rate == 2'd0) ? 1 : (mode_rate == 2'd1) ? 16 : 64;
               m_char = 8'h00; m_acc = 0; m_pos = 0;
               if (m_factor == 1) begin m_phase = 2; m_wait = 1; end
               else begin m_phase = 1; m_wait = m_factor / 2; end
            end
         end else begin
            m_wait--;
            if (m_wait == 0) begin
               m_wait = m_factor;
               case (m_phase)
                  1: m_phase = rxd ? 0 : 2;
                  2: begin
                     m_char[m_pos] = rxd;
                     m_acc ^= int'(rxd);
                     m_pos++;
                     if (m_pos == m_nbits) m_phase = m_pen ? 3 : 4;
                  end
                  3: begin m_acc ^= int'(rxd); m_phase = 4; end
                  default: begin
                     ld = 1; nfe = !rxd;
                     npe = m_pen && (m_acc != (m_even ? 0 : 1));
                     m_phase = 0;
                  end
               endcase
            end
         end
         e_pe = (e_pe && !err_clear) || npe;
         e_fe = (e_fe && !err_clear) || nfe;
         e_oe = (e_oe && !err_clear) || (ld && e_ready && !rd_strobe);
         if (ld) begin e_data = m_char; e_ready = 1; end
         else if (rd_strobe) e_ready = 0;
         m_prev = rxd;
      end
   end

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(rx_data === e_data,       "R3 model data",     rx_data, e_data);
         chk(rx_ready === e_ready,     "R8 model ready",    rx_ready, e_ready);
         chk(err_parity === e_pe,      "R6 model parity",   err_parity, e_pe);
         chk(err_frame === e_fe,       "R7 model frame",    err_frame, e_fe);
         chk(err_overrun === e_oe,     "R9 model overrun",  err_overrun, e_oe);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic put(input logic v, input int cycles);
      rxd = v;
      repeat (cycles) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] d, input int n, input int f, input bit pen,
                       input bit even, input bit bad_par, input logic stop);
      bit p;
      p = 0;
      put(1'b0, f);
      for (int i = 0; i < n; i++) begin
         put(d[i], f);
         p ^= d[i];
      end
      if (pen) begin
         if (!even) p = ~p;
         if (bad_par) p = ~p;
         put(p, f);
      end
      put(stop, f);
      put(1'b1, f);
   endtask

   task automatic read_pulse();
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
   endtask

   task automatic clear_pulse();
      err_clear = 1'b1;
      @(negedge clk);
      err_clear = 1'b0;
   endtask

   task automatic set_mode(input logic [1:0] len, input bit pen, input bit even,
                           input logic [1:0] rate);
      mode_len = len; mode_par_en = pen; mode_par_even = even; mode_rate = rate;
   endtask

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   // ---------------- directed sequence ----------------
   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset values
      chk(rx_data == 8'h00 && !rx_ready, "R1 reset data/ready", {rx_ready, rx_data}, 0);
      chk(!err_parity && !err_frame && !err_overrun, "R1 reset flags",
          {err_parity, err_frame, err_overrun}, 0);
      repeat (40) @(negedge clk);
      chk(!rx_ready, "R1 idle line gives no character", rx_ready, 0);

      // R3/R8: 16x, 8 bits, no parity
      set_mode(2'd3, 0, 0, 2'd1);
      send(8'hA5, 8, 16, 0, 0, 0, 1'b1);
      chk(rx_data == 8'hA5, "R3 16x eight-bit character", rx_data, 8'hA5);
      chk(rx_ready, "R8 ready after load", rx_ready, 1);
      read_pulse();
      chk(!rx_ready, "R8 read clears ready", rx_ready, 0);
      chk(rx_data == 8'hA5, "R8 data kept after read", rx_data, 8'hA5);

      // R6: 64x (code 2), 7 bits, even parity good then bad
      set_mode(2'd2, 1, 1, 2'd2);
      send(8'h5A, 7, 64, 1, 1, 0, 1'b1);
      chk(rx_data == 8'h5A && !err_parity, "R6 even parity good", {err_parity, rx_data}, 8'h5A);
      read_pulse();
      send(8'h33, 7, 64, 1, 1, 1, 1'b1);
      chk(err_parity, "R6 even parity mismatch flagged", err_parity, 1);
      chk(rx_data == 8'h33, "R6 bad-parity char still delivered", rx_data, 8'h33);
      read_pulse();
      clear_pulse();
      chk(!err_parity, "R10 clear drops parity flag", err_parity, 0);

      // R3/R6: rate code 3 also 64x, odd parity, 8 bits
      set_mode(2'd3, 1, 0, 2'd3);
      send(8'hC3, 8, 64, 1, 0, 0, 1'b1);
      chk(rx_data == 8'hC3 && !err_parity, "R3 rate code 3 odd parity good",
          {err_parity, rx_data}, 8'hC3);
      read_pulse();
      send(8'hC2, 8, 64, 1, 0, 1, 1'b1);
      chk(err_parity, "R6 odd parity mismatch flagged", err_parity, 1);
      read_pulse();
      clear_pulse();

      // R5: short characters zero-filled
      set_mode(2'd0, 0, 0, 2'd1);
      send(8'hFF, 5, 16, 0, 0, 0, 1'b1);
      chk(rx_data == 8'h1F, "R5 five-bit character zero fill", rx_data, 8'h1F);
      read_pulse();
      set_mode(2'd1, 0, 0, 2'd1);
      send(8'hEA, 6, 16, 0, 0, 0, 1'b1);
      chk(rx_data == 8'h2A, "R5 six-bit character zero fill", rx_data, 8'h2A);
      read_pulse();

      // R7/R10: framing error, sticky, reception continues
      set_mode(2'd3, 0, 0, 2'd1);
      send(8'h81, 8, 16, 0, 0, 0, 1'b0);
      chk(err_frame, "R7 low stop bit flagged", err_frame, 1);
      chk(rx_data == 8'h81 && rx_ready, "R7 framed-bad char delivered", rx_data, 8'h81);
      read_pulse();
      send(8'h42, 8, 16, 0, 0, 0, 1'b1);
      chk(rx_data == 8'h42, "R10 reception continues after error", rx_data, 8'h42);
      chk(err_frame, "R10 frame flag sticky", err_frame, 1);
      read_pulse();
      clear_pulse();
      chk(!err_frame, "R10 clear drops frame flag", err_frame, 0);

      // R9: overrun
      send(8'h11, 8, 16, 0, 0, 0, 1'b1);
      send(8'h22, 8, 16, 0, 0, 0, 1'b1);
      chk(err_overrun, "R9 overrun flagged", err_overrun, 1);
      chk(rx_data == 8'h22, "R9 newer char replaces older", rx_data, 8'h22);
      read_pulse();
      clear_pulse();
      chk(!err_overrun, "R10 clear drops overrun flag", err_overrun, 0);

      // R2: glitch shorter than half a bit is rejected
      put(1'b0, 4);
      put(1'b1, 48);
      chk(!rx_ready && rx_data == 8'h22, "R2 glitch rejected", {rx_ready, rx_data}, 8'h22);
      send(8'h3C, 8, 16, 0, 0, 0, 1'b1);
      chk(rx_data == 8'h3C, "R2 next real start accepted", rx_data, 8'h3C);
      read_pulse();

      // R4: 1x mode
      set_mode(2'd3, 0, 0, 2'd0);
      put(1'b1, 4);
      send(8'h96, 8, 1, 0, 0, 0, 1'b1);
      chk(rx_data == 8'h96, "R4 1x character", rx_data, 8'h96);
      read_pulse();
      put(1'b1, 3);
      send(8'h69, 8, 1, 1, 1, 0, 1'b1);
      chk(rx_data == 8'h69, "R4 1x character (mode reapplied)", rx_data, 8'h69);
      read_pulse();
      put(1'b1, 3);
      put(1'b0, 1);
      put(1'b1, 20);
      chk(rx_data == 8'hFF && rx_ready, "R4 one-clock low taken as start in 1x",
          rx_data, 8'hFF);
      read_pulse();

      // R11: mode change mid-character has no effect on it
      set_mode(2'd3, 0, 0, 2'd1);
      put(1'b1, 4);
      fork
         send(8'hB7, 8, 16, 0, 0, 0, 1'b1);
         begin
            repeat (24) @(negedge clk);
            mode_len = 2'd0;
         end
      join
      chk(rx_data == 8'hB7, "R11 mode latched at start edge", rx_data, 8'hB7);
      read_pulse();
      send(8'hFF, 5, 16, 0, 0, 0, 1'b1);
      chk(rx_data == 8'h1F, "R11 new length used on next character", rx_data, 8'h1F);

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule